// File: doc/BRIEF.md
# Dual-Format Palette Register File

This block stores the colour tables of a video controller in two formats. A small legacy table holds 16 entries of 12-bit colour, with four bits per channel. A large extended table holds 256 entries, each a 32-bit word that carries a 6-bit red, green and blue field. A bus write port updates either table with byte, word or long transfers. Each table applies its own masking and merging rules to these writes.

A lookup port takes a colour index and a table-select flag. It returns 24-bit RGB after exactly one clock. The legacy 4-bit channels are stored with their bits rotated, and the lookup unscrambles them while it widens each channel to 8 bits. Extended channels are widened by copying their top bits into the spare low bits. Extended entry 0 also drives a separate registered border colour output. That output stays valid in every mode, including the direct-colour mode where the lookup port is not used.

Top module: `dual_palette_rf`

## Requirements
- R1: A synchronous active-high reset clears every entry of both tables to zero; after reset `rgb` and `border_rgb` read 0 and every lookup returns 0.
- R2: A byte write (`wr_size`=0) to a legacy entry, selected by `wr_addr[4:1]`, copies the data byte `wr_data[7:0]` into both halves of the 16-bit word before masking to the low 12 bits. `wr_addr[0]` has no effect, so writing 0x71 stores 0x171.
- R3: A word write (`wr_size`=1) to a legacy entry stores `wr_data[15:0]` masked to 12 bits. A long write (`wr_size`=2) updates the even/odd entry pair that contains `wr_addr[4:1]`: `wr_data[31:16]` goes to the even entry and `wr_data[15:0]` to the odd entry, each masked to 12 bits.
- R4: A long write to the extended entry `wr_addr[9:2]` stores `wr_data` ANDed with 0xFCFC00FC.
- R5: Byte and word writes to an extended entry first merge into the stored word, then apply the same mask. Byte lanes are big-endian: `wr_addr[1:0]`=0 selects bits 31:24 and 3 selects bits 7:0. A word write with `wr_addr[1]`=0 replaces bits 31:16, and with `wr_addr[1]`=1 it replaces bits 15:0.
- R6: A legacy entry holds red in bits 11:8, green in bits 7:4 and blue in bits 3:0. Each 4-bit channel c becomes n = {c[2:0], c[3]}, and the 8-bit output is {n, n}.
- R7: An extended entry holds red in bits 31:26, green in bits 23:18 and blue in bits 7:2. Each 6-bit field v becomes {v, v[5:4]}.
- R8: `rgb` is {red, green, blue}, with red in bits 23:16. It is registered: the value seen after a clock edge reflects the `lk_idx` and `lk_ext` sampled at that same edge, using the table contents written before it. `lk_ext`=1 selects the extended table.
- R9: `border_rgb` is the R7 expansion of extended entry 0. It is registered, does not depend on `lk_ext`, and shows a write to entry 0 one clock after that write.
- R10: A legacy lookup uses only `lk_idx[3:0]`.
- R11: A write with `wr_size`=3 changes neither table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_ext | input | 1 | Write target: 0 legacy table, 1 extended table |
| wr_size | input | 2 | Transfer size: 0 byte, 1 word, 2 long, 3 none |
| wr_addr | input | 10 | Byte offset within the selected table |
| wr_data | input | 32 | Write data, right-aligned for byte and word |
| lk_idx | input | 8 | Lookup colour index |
| lk_ext | input | 1 | Lookup table select: 1 extended |
| rgb | output | 24 | Registered lookup result |
| border_rgb | output | 24 | Registered border colour from extended entry 0 |

## Verification
A write becomes visible in the tables at the clock edge that samples it, and a lookup result appears at the edge that samples its index. The bench therefore drives a write on one falling edge and removes it on the next. It then presents the lookup on that same falling edge and reads `rgb` one falling edge later, so exactly one rising edge lies between stimulus and sample. The border output needs one more edge after a write to entry 0, so the bench checks it both one half-cycle after the write edge (expecting the old value) and one cycle later (expecting the new value). The select flag is switched on back-to-back cycles to show that it pairs with the index sampled at the same edge.

// File: rtl/dpal_pkg.sv
package dpal_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } xfer_size_e;

  localparam logic [31:0] EXT_KEEP = 32'hFCFC_00FC;
  localparam logic [15:0] LEG_KEEP = 16'h0FFF;

  // rotated 4-bit channel to 8 bits
  function automatic logic [7:0] leg_chan(input logic [3:0] c);
    logic [3:0] n;
    n = {c[2:0], c[3]};
    return {n, n};
  endfunction

  function automatic logic [23:0] leg_rgb(input logic [15:0] e);
    return {leg_chan(e[11:8]), leg_chan(e[7:4]), leg_chan(e[3:0])};
  endfunction

  function automatic logic [7:0] ext_chan(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [23:0] ext_rgb(input logic [31:0] e);
    return {ext_chan(e[31:26]), ext_chan(e[23:18]), ext_chan(e[7:2])};
  endfunction

endpackage

// File: rtl/dpal_leg_bank.sv
module dpal_leg_bank
  import dpal_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       size,
  input  logic [$clog2(N_ENT):0] addr,
  input  logic [31:0]      data,
  input  logic [$clog2(N_ENT)-1:0] rd_idx,
  output logic [15:0]      rd_val
);
  localparam int IW = $clog2(N_ENT);

  logic [15:0] mem [N_ENT];

  logic [IW-1:0] ent, pair_lo, pair_hi;
  logic [15:0]   mirrored;
  logic          byte_wr_ev, word_wr_ev, long_wr_ev;

  assign ent        = addr[IW:1];
  assign pair_lo    = {ent[IW-1:1], 1'b0};
  assign pair_hi    = {ent[IW-1:1], 1'b1};
  assign mirrored   = {data[7:0], data[7:0]} & LEG_KEEP;
  assign byte_wr_ev = we && (size == SZ_BYTE);
  assign word_wr_ev = we && (size == SZ_WORD);
  assign long_wr_ev = we && (size == SZ_LONG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) mem[i] <= '0;
    end else if (byte_wr_ev) begin
      mem[ent] <= mirrored;
    end else if (word_wr_ev) begin
      mem[ent] <= data[15:0] & LEG_KEEP;
    end else if (long_wr_ev) begin
      mem[pair_lo] <= data[31:16] & LEG_KEEP;
      mem[pair_hi] <= data[15:0] & LEG_KEEP;
    end
  end

  assign rd_val = mem[rd_idx];

  // R2: byte mirrored into both halves, then masked
  p_leg_byte_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    byte_wr_ev |=> mem[$past(ent)] == {4'h0, $past(data[3:0]), $past(data[7:0])});

  // R3: long write fills the aligned pair
  p_leg_long_pair_r3: assert property (@(posedge clk) disable iff (rst)
    long_wr_ev |=> (mem[$past(pair_lo)] == {4'h0, $past(data[27:16])}) &&
                   (mem[$past(pair_hi)] == {4'h0, $past(data[11:0])}));

  // R3: word write keeps only 12 bits
  p_leg_word_r3: assert property (@(posedge clk) disable iff (rst)
    word_wr_ev |=> mem[$past(ent)] == {4'h0, $past(data[11:0])});

endmodule

// File: rtl/dpal_ext_bank.sv
module dpal_ext_bank
  import dpal_pkg::*;
#(
  parameter int N_ENT = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       size,
  input  logic [$clog2(N_ENT)+1:0] addr,
  input  logic [31:0]      data,
  input  logic [$clog2(N_ENT)-1:0] rd_idx,
  output logic [31:0]      rd_val,
  output logic [31:0]      ent0_val
);
  localparam int IW = $clog2(N_ENT);

  logic [31:0] mem [N_ENT];

  logic [IW-1:0] ent;
  logic [1:0]    lane;
  logic [31:0]   cur, merged;
  logic          ext_wr_ev, long_wr_ev;

  assign ent        = addr[IW+1:2];
  assign lane       = addr[1:0];
  assign cur        = mem[ent];
  assign ext_wr_ev  = we && (size != SZ_NONE);
  assign long_wr_ev = we && (size == SZ_LONG);

  // big-endian lane merge before the mask
  always_comb begin
    merged = cur;
    case (size)
      SZ_BYTE: begin
        case (lane)
          2'd0:    merged[31:24] = data[7:0];
          2'd1:    merged[23:16] = data[7:0];
          2'd2:    merged[15:8]  = data[7:0];
          default: merged[7:0]   = data[7:0];
        endcase
      end
      SZ_WORD: begin
        if (lane[1]) merged[15:0]  = data[15:0];
        else         merged[31:16] = data[15:0];
      end
      SZ_LONG: merged = data;
      default: merged = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) mem[i] <= '0;
    end else if (ext_wr_ev) begin
      mem[ent] <= merged & EXT_KEEP;
    end
  end

  assign rd_val   = mem[rd_idx];
  assign ent0_val = mem[0];

  // R4/R5: unused bits never stored
  p_ext_mask_r5: assert property (@(posedge clk) disable iff (rst)
    ext_wr_ev |=> (mem[$past(ent)] & ~EXT_KEEP) == 32'h0);

  // R4: long write stores masked data
  p_ext_long_r4: assert property (@(posedge clk) disable iff (rst)
    long_wr_ev |=> mem[$past(ent)] == ($past(data) & EXT_KEEP));

endmodule

// File: rtl/dual_palette_rf.sv
module dual_palette_rf
  import dpal_pkg::*;
#(
  parameter int LEG_N = 16,
  parameter int EXT_N = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_ext,
  input  logic [1:0]  wr_size,
  input  logic [$clog2(EXT_N)+1:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [$clog2(EXT_N)-1:0] lk_idx,
  input  logic        lk_ext,
  output logic [23:0] rgb,
  output logic [23:0] border_rgb
);
  localparam int LIW = $clog2(LEG_N);

  logic        leg_we, ext_we;
  logic [15:0] leg_rd;
  logic [31:0] ext_rd, ext0;

  assign leg_we = wr_en && !wr_ext;
  assign ext_we = wr_en &&  wr_ext;

  dpal_leg_bank #(.N_ENT(LEG_N)) u_leg (
    .clk(clk), .rst(rst), .we(leg_we), .size(wr_size),
    .addr(wr_addr[LIW:0]), .data(wr_data),
    .rd_idx(lk_idx[LIW-1:0]), .rd_val(leg_rd)
  );

  dpal_ext_bank #(.N_ENT(EXT_N)) u_ext (
    .clk(clk), .rst(rst), .we(ext_we), .size(wr_size),
    .addr(wr_addr), .data(wr_data),
    .rd_idx(lk_idx), .rd_val(ext_rd), .ent0_val(ext0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb        <= '0;
      border_rgb <= '0;
    end else begin
      rgb        <= lk_ext ? ext_rgb(ext_rd) : leg_rgb(leg_rd);
      border_rgb <= ext_rgb(ext0);
    end
  end

  // R1: outputs cleared right after reset
  p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rgb == 24'h0) && (border_rgb == 24'h0));

  // R8: unchanged lookup and no write gives an unchanged result
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(lk_idx) && $stable(lk_ext))
      |=> $stable(rgb));

  // R9: border only moves after a write
  p_border_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |=> $stable(border_rgb));

endmodule

// File: tb/tb_dual_palette_rf.sv
module tb_dual_palette_rf;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_ext;
  logic [1:0]  wr_size;
  logic [9:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  lk_idx;
  logic        lk_ext;
  logic [23:0] rgb, border_rgb;

  int checks = 0;
  int fails  = 0;

  logic [15:0] lm [16];
  logic [31:0] em [256];

  always #10 clk = ~clk;

  dual_palette_rf dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ext(wr_ext), .wr_size(wr_size),
    .wr_addr(wr_addr), .wr_data(wr_data), .lk_idx(lk_idx), .lk_ext(lk_ext),
    .rgb(rgb), .border_rgb(border_rgb)
  );

  function automatic int leg_c8(input int c);
    int n;
    n = (c % 8) * 2 + c / 8;
    return n * 17;
  endfunction

  function automatic logic [23:0] exp_leg(input logic [15:0] e);
    int v;
    v = int'(e);
    return 24'(leg_c8((v / 256) % 16) * 65536 + leg_c8((v / 16) % 16) * 256 + leg_c8(v % 16));
  endfunction

  function automatic int ext_c8(input int v6);
    return v6 * 4 + v6 / 16;
  endfunction

  function automatic logic [23:0] exp_ext(input logic [31:0] e);
    int r, g, b;
    r = int'(e >> 26) % 64;
    g = int'(e >> 18) % 64;
    b = int'(e >> 2) % 64;
    return 24'(ext_c8(r) * 65536 + ext_c8(g) * 256 + ext_c8(b));
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %06h expected %06h", req, got, exp);
    end
  endtask

  // model update computed from the requirements
  task automatic model_write(input bit ext, input int sz, input int a, input logic [31:0] d);
    int e, sh;
    logic [31:0] w;
    if (sz == 3) return;
    if (!ext) begin
      e = (a / 2) % 16;
      if (sz == 0) lm[e] = 16'((int'(d[7:0]) * 257) % 4096);
      else if (sz == 1) lm[e] = 16'(int'(d[15:0]) % 4096);
      else begin
        e = e - (e % 2);
        lm[e]     = 16'(d >> 16) & 16'h0FFF;
        lm[e + 1] = d[15:0] & 16'h0FFF;
      end
    end else begin
      e = (a / 4) % 256;
      w = em[e];
      if (sz == 0) begin
        sh = (3 - a % 4) * 8;
        w = (w & ~(32'hFF << sh)) | ({24'h0, d[7:0]} << sh);
      end else if (sz == 1) begin
        sh = ((a / 2) % 2 == 1) ? 0 : 16;
        w = (w & ~(32'hFFFF << sh)) | ({16'h0, d[15:0]} << sh);
      end else w = d;
      em[e] = w & 32'hFCFC00FC;
    end
  endtask

  task automatic wr(input bit ext, input int sz, input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ext = ext; wr_size = 2'(sz); wr_addr = 10'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(ext, sz, a, d);
  endtask

  task automatic look(input bit ext, input int idx, output logic [23:0] got);
    lk_ext = ext; lk_idx = 8'(idx);
    @(negedge clk);
    got = rgb;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [23:0] g;
    rst = 1'b1; wr_en = 0; wr_ext = 0; wr_size = 0; wr_addr = 0; wr_data = 0;
    lk_idx = 0; lk_ext = 0;
    for (int i = 0; i < 16; i++) lm[i] = '0;
    for (int i = 0; i < 256; i++) em[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rgb", rgb, 24'h0);
    check("R1 border", border_rgb, 24'h0);
    for (int i = 0; i < 16; i++) begin look(1'b0, i, g); check("R1 legacy", g, 24'h0); end
    for (int i = 0; i < 256; i += 17) begin look(1'b1, i, g); check("R1 ext", g, 24'h0); end

    // R3/R6 word writes to every legacy entry, top nibble set to test mask
    for (int i = 0; i < 16; i++)
      wr(1'b0, 1, 2 * i + (i % 2), 32'hDEAD_0000 | 32'(16'hF000 | (i * 16'h0111 ^ 16'h0A53)));
    for (int i = 0; i < 16; i++) begin look(1'b0, i, g); check("R3 R6 word", g, exp_leg(lm[i])); end

    // R2 byte mirror: upper and lower byte
    wr(1'b0, 0, 6, 32'h0000_0071);
    look(1'b0, 3, g); check("R2 upper", g, exp_leg(16'h0171));
    wr(1'b0, 0, 11, 32'hFFFF_FF55);
    look(1'b0, 5, g); check("R2 lower", g, exp_leg(16'h0555));

    // R3 long: aligned and odd start both hit pair 4/5
    wr(1'b0, 2, 8, 32'hF123_E456);
    look(1'b0, 4, g); check("R3 long even", g, exp_leg(16'h0123));
    look(1'b0, 5, g); check("R3 long odd", g, exp_leg(16'h0456));
    wr(1'b0, 2, 10, 32'h0789_0ABC);
    look(1'b0, 4, g); check("R3 long pair4", g, exp_leg(lm[4]));
    look(1'b0, 5, g); check("R3 long pair5", g, exp_leg(lm[5]));

    // R10 high index bits ignored in legacy
    look(1'b0, 8'h35, g); check("R10", g, exp_leg(lm[5]));
    look(1'b0, 8'hFC, g); check("R10", g, exp_leg(lm[12]));

    // R4/R7 long writes to every extended entry
    for (int i = 0; i < 256; i++)
      wr(1'b1, 2, 4 * i, {8'(i), ~8'(i), 8'(i) ^ 8'h5A, 8'(i + 1)} | 32'h0303_0003);
    for (int i = 0; i < 256; i++) begin look(1'b1, i, g); check("R4 R7 long", g, exp_ext(em[i])); end

    // R5 byte and word lanes on entry 7
    for (int ln = 0; ln < 4; ln++) begin
      wr(1'b1, 0, 28 + ln, 32'h0000_00FF - 32'(ln * 16'h0041));
      look(1'b1, 7, g); check("R5 byte lane", g, exp_ext(em[7]));
    end
    wr(1'b1, 1, 28, 32'h0000_13F7);
    look(1'b1, 7, g); check("R5 word hi", g, exp_ext(em[7]));
    wr(1'b1, 1, 30, 32'h0000_5A9B);
    look(1'b1, 7, g); check("R5 word lo", g, exp_ext(em[7]));

    // R11 size 3 writes nothing
    wr(1'b1, 3, 28, 32'hFFFF_FFFF);
    look(1'b1, 7, g); check("R11 ext", g, exp_ext(em[7]));
    wr(1'b0, 3, 6, 32'hFFFF_FFFF);
    look(1'b0, 3, g); check("R11 legacy", g, exp_leg(lm[3]));

    // R8 select sampled with index, back to back
    lk_ext = 1'b0; lk_idx = 8'd9;
    @(negedge clk);
    check("R8 legacy", rgb, exp_leg(lm[9]));
    lk_ext = 1'b1;
    @(negedge clk);
    check("R8 ext", rgb, exp_ext(em[9]));
    lk_ext = 1'b0; lk_idx = 8'd2;
    @(negedge clk);
    check("R8 switch back", rgb, exp_leg(lm[2]));

    // R9 border: latency and independence from select
    lk_ext = 1'b0;
    @(negedge clk);
    check("R9 border init", border_rgb, exp_ext(em[0]));
    g = exp_ext(em[0]);
    wr(1'b1, 2, 0, 32'hA4C8_11F0);
    check("R9 border not yet", border_rgb, g);
    @(negedge clk);
    check("R9 border new", border_rgb, exp_ext(em[0]));
    lk_ext = 1'b1; lk_idx = 8'd200;
    @(negedge clk);
    check("R9 border held", border_rgb, exp_ext(em[0]));

    // R1 reset again clears tables
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) lm[i] = '0;
    for (int i = 0; i < 256; i++) em[i] = '0;
    look(1'b1, 7, g); check("R1 re-reset ext", g, 24'h0);
    look(1'b0, 5, g); check("R1 re-reset legacy", g, 24'h0);
    check("R1 re-reset border", border_rgb, 24'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule